// File: doc/BRIEF.md
# MSI Snooping Cache-Line Coherence Controller

This block tracks the coherence state of one cache line that sits on a shared snooping bus. The processor side sends load, store and evict requests. The bus side brings in remote read and read-for-ownership snoops, plus a grant that tells the line its own bus request has been served. Misses, upgrades and writebacks cannot finish at once, so the controller holds each one in a transient waiting state. A snoop that arrives during that wait is handled in that state, and the line never ends up holding a copy it has lost.

Every processed event that changes the state or produces an action appears for one cycle on a transition record. The record carries the line address, the old state, the new state, the input code and the action code, so an independent checker next to the cache can verify each step against a simpler protocol model. Only one operation can be outstanding. While the line is waiting, processor requests are held off with a ready-low handshake.

Top module: `msi_line_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the state at 0 (invalid), all bus requests low, `cpu_done` and `tr_valid` low, and `cpu_ready` high once reset is released.
- R2: `state_o` uses the codes 0 invalid, 1 shared, 2 modified, 3 waiting for a read fill, 4 waiting for ownership from invalid, 5 waiting for ownership from shared, and 6 waiting for a writeback. Code 7 never appears. The registered bus requests follow the state: `bus_rd` is high only in 3, `bus_rdx` only in 4 or 5, `bus_wb` only in 6, and at most one of them is high at a time.
- R3: A load in state 0 moves to 3 with action 1 (issue read). A grant in 3 moves to 1 with action 5 (finish) and pulses `cpu_done`.
- R4: A store in state 0 moves to 4, and a store in state 1 moves to 5, both with action 2 (issue read-exclusive). A grant in 4 or 5 moves to 2 with action 5 and pulses `cpu_done`.
- R5: A remote read-exclusive snooped in state 5 moves the line to 4 with action 6 (drop copy). The read-exclusive request stays asserted and `cpu_done` stays low.
- R6: An evict in state 2 moves to 6 with action 3 (issue writeback).
  - In state 6, a remote read supplies data (action 4) and the line stays in 6.
  - A remote read-exclusive in state 6 supplies data and ends in 0. It also completes the evict with a `cpu_done` pulse.
  - A grant in state 6 moves to 0 with action 5 and a `cpu_done` pulse.
- R7: In state 2, a remote read moves the line to 1 and a remote read-exclusive moves it to 0. Both use action 4 (supply data).
- R8: In state 1, a remote read-exclusive moves to 0 with action 6 and no `cpu_done`. An evict in state 1 moves to 0 with action 6 and pulses `cpu_done`.
- R9: These requests complete without a state change and without a record: a load in 1 or 2, a store in 2, and an evict in 0. Each pulses `cpu_done` one cycle after acceptance. A grant in a stable state, a remote read in 0 or 1, and a snoop in 3 or 4 have no effect.
- R10: `cpu_ready` is high only in states 0 to 2 with no snoop present in that cycle. A request made while `cpu_ready` is low is ignored. `cpu_op` codes are 0 load, 1 store and 2 evict. Code 3 is ignored.
- R11: Only one event is taken per cycle, in this priority: remote read-exclusive, then remote read, then grant (only in a waiting state), then processor request. A grant that loses to a snoop is not used, and the bus request stays asserted.
- R12: Each state change or non-zero action raises `tr_valid` for exactly one cycle, on the clock edge that takes the event. In that same cycle the record shows `tr_addr`, `tr_old`, `tr_new`, `tr_input` and `tr_action`. The input codes are 1 load, 2 store, 3 evict, 4 remote read, 5 remote read-exclusive and 6 grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_addr | input | AW | Address of the tracked line, copied into the record |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Request kind: 0 load, 1 store, 2 evict |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse to the processor |
| snp_rd | input | 1 | Remote read snooped on the bus |
| snp_rdx | input | 1 | Remote read-exclusive snooped on the bus |
| bus_grant | input | 1 | Own bus request has been served |
| bus_rd | output | 1 | Read request to the bus |
| bus_rdx | output | 1 | Read-exclusive request to the bus |
| bus_wb | output | 1 | Writeback request to the bus |
| state_o | output | 3 | Current line state code |
| tr_valid | output | 1 | Transition record valid |
| tr_addr | output | AW | Record: line address |
| tr_old | output | 3 | Record: state before the event |
| tr_new | output | 3 | Record: state after the event |
| tr_input | output | 3 | Record: input code |
| tr_action | output | 3 | Record: action code |

## Verification
The properties assume that `bus_grant` is raised only while the line has a request outstanding, and that the processor holds a request at most one cycle unless `cpu_ready` says it was taken. The snoop properties are stated with the other snoop input low where the priority matters. The directed bench drives every input for exactly one cycle between falling edges. It raises grants only in waiting states, except in one deliberate case that checks a grant in a stable state is ignored. It combines snoops with grants or requests only in the priority scenarios, and those scenarios state their expected winner.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [2:0] {
    ST_INV        = 3'd0,
    ST_SHR        = 3'd1,
    ST_MOD        = 3'd2,
    ST_WAIT_RD    = 3'd3,
    ST_WAIT_OWN_I = 3'd4,
    ST_WAIT_OWN_S = 3'd5,
    ST_WAIT_WB    = 3'd6
  } line_st_e;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_LD      = 3'd1,
    EV_ST      = 3'd2,
    EV_EVICT   = 3'd3,
    EV_SNP_RD  = 3'd4,
    EV_SNP_RDX = 3'd5,
    EV_GRANT   = 3'd6
  } line_ev_e;

  typedef enum logic [2:0] {
    AC_NONE      = 3'd0,
    AC_ISSUE_RD  = 3'd1,
    AC_ISSUE_RDX = 3'd2,
    AC_ISSUE_WB  = 3'd3,
    AC_SUPPLY    = 3'd4,
    AC_FINISH    = 3'd5,
    AC_DROP      = 3'd6
  } line_ac_e;

  function automatic logic st_waiting(line_st_e s);
    return (s == ST_WAIT_RD) || (s == ST_WAIT_OWN_I) ||
           (s == ST_WAIT_OWN_S) || (s == ST_WAIT_WB);
  endfunction

endpackage

// File: rtl/msi_event_sel.sv
module msi_event_sel
  import msi_pkg::*;
(
  input  line_st_e   cur,
  input  logic       cpu_valid,
  input  logic [1:0] cpu_op,
  input  logic       snp_rd,
  input  logic       snp_rdx,
  input  logic       bus_grant,
  output line_ev_e   ev,
  output logic       ready
);

  logic waiting;
  logic snoop_any;

  always_comb begin
    waiting   = st_waiting(cur);
    snoop_any = snp_rd | snp_rdx;
    ready     = !waiting && !snoop_any;
    ev        = EV_NONE;
    if (snp_rdx)                    ev = EV_SNP_RDX;
    else if (snp_rd)                ev = EV_SNP_RD;
    else if (bus_grant && waiting)  ev = EV_GRANT;
    else if (cpu_valid && ready) begin
      case (cpu_op)
        2'd0:    ev = EV_LD;
        2'd1:    ev = EV_ST;
        2'd2:    ev = EV_EVICT;
        default: ev = EV_NONE;
      endcase
    end
  end

endmodule

// File: rtl/msi_next_state.sv
module msi_next_state
  import msi_pkg::*;
(
  input  line_st_e cur,
  input  line_ev_e ev,
  output line_st_e nxt,
  output line_ac_e act,
  output logic     done
);

  always_comb begin
    nxt  = cur;
    act  = AC_NONE;
    done = 1'b0;
    case (cur)
      ST_INV: begin
        case (ev)
          EV_LD:    begin nxt = ST_WAIT_RD;    act = AC_ISSUE_RD;  end
          EV_ST:    begin nxt = ST_WAIT_OWN_I; act = AC_ISSUE_RDX; end
          EV_EVICT: done = 1'b1;
          default:  ;
        endcase
      end
      ST_SHR: begin
        case (ev)
          EV_LD:      done = 1'b1;
          EV_ST:      begin nxt = ST_WAIT_OWN_S; act = AC_ISSUE_RDX; end
          EV_EVICT:   begin nxt = ST_INV; act = AC_DROP; done = 1'b1; end
          EV_SNP_RDX: begin nxt = ST_INV; act = AC_DROP; end
          default:    ;
        endcase
      end
      ST_MOD: begin
        case (ev)
          EV_LD, EV_ST: done = 1'b1;
          EV_EVICT:     begin nxt = ST_WAIT_WB; act = AC_ISSUE_WB; end
          EV_SNP_RD:    begin nxt = ST_SHR; act = AC_SUPPLY; end
          EV_SNP_RDX:   begin nxt = ST_INV; act = AC_SUPPLY; end
          default:      ;
        endcase
      end
      ST_WAIT_RD: begin
        if (ev == EV_GRANT) begin
          nxt = ST_SHR; act = AC_FINISH; done = 1'b1;
        end
      end
      ST_WAIT_OWN_I: begin
        if (ev == EV_GRANT) begin
          nxt = ST_MOD; act = AC_FINISH; done = 1'b1;
        end
      end
      ST_WAIT_OWN_S: begin
        case (ev)
          EV_SNP_RDX: begin nxt = ST_WAIT_OWN_I; act = AC_DROP; end
          EV_GRANT:   begin nxt = ST_MOD; act = AC_FINISH; done = 1'b1; end
          default:    ;
        endcase
      end
      ST_WAIT_WB: begin
        case (ev)
          EV_SNP_RD:  act = AC_SUPPLY;
          EV_SNP_RDX: begin nxt = ST_INV; act = AC_SUPPLY; done = 1'b1; end
          EV_GRANT:   begin nxt = ST_INV; act = AC_FINISH; done = 1'b1; end
          default:    ;
        endcase
      end
      default: nxt = ST_INV;
    endcase
  end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int AW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] line_addr,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  output logic          cpu_ready,
  output logic          cpu_done,
  input  logic          snp_rd,
  input  logic          snp_rdx,
  input  logic          bus_grant,
  output logic          bus_rd,
  output logic          bus_rdx,
  output logic          bus_wb,
  output logic [2:0]    state_o,
  output logic          tr_valid,
  output logic [AW-1:0] tr_addr,
  output logic [2:0]    tr_old,
  output logic [2:0]    tr_new,
  output logic [2:0]    tr_input,
  output logic [2:0]    tr_action
);

  line_st_e state_q;
  line_st_e nxt;
  line_ev_e ev;
  line_ac_e act;
  logic     done_c;
  logic     rec_c;

  msi_event_sel u_sel (
    .cur       (state_q),
    .cpu_valid (cpu_valid),
    .cpu_op    (cpu_op),
    .snp_rd    (snp_rd),
    .snp_rdx   (snp_rdx),
    .bus_grant (bus_grant),
    .ev        (ev),
    .ready     (cpu_ready)
  );

  msi_next_state u_ns (
    .cur  (state_q),
    .ev   (ev),
    .nxt  (nxt),
    .act  (act),
    .done (done_c)
  );

  assign rec_c = (nxt != state_q) || (act != AC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_INV;
      bus_rd    <= 1'b0;
      bus_rdx   <= 1'b0;
      bus_wb    <= 1'b0;
      cpu_done  <= 1'b0;
      tr_valid  <= 1'b0;
      tr_addr   <= '0;
      tr_old    <= 3'd0;
      tr_new    <= 3'd0;
      tr_input  <= 3'd0;
      tr_action <= 3'd0;
    end else begin
      state_q  <= nxt;
      bus_rd   <= (nxt == ST_WAIT_RD);
      bus_rdx  <= (nxt == ST_WAIT_OWN_I) || (nxt == ST_WAIT_OWN_S);
      bus_wb   <= (nxt == ST_WAIT_WB);
      cpu_done <= done_c;
      tr_valid <= rec_c;
      if (rec_c) begin
        tr_addr   <= line_addr;
        tr_old    <= state_q;
        tr_new    <= nxt;
        tr_input  <= ev;
        tr_action <= act;
      end
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       bus_rd,
  input logic       bus_rdx,
  input logic       bus_wb,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic       bus_grant,
  input logic       snp_rd,
  input logic       snp_rdx,
  input logic       tr_valid,
  input logic [2:0] tr_old,
  input logic [2:0] tr_new,
  input logic [2:0] tr_action
);

  assert_one_req_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_rdx, bus_wb}));

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (rst)
    state_o != 3'd7);

  assert_wait_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o >= 3'd3) |-> !cpu_ready);

  assert_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && bus_grant && !snp_rd && !snp_rdx)
      |=> (state_o == 3'd1 && cpu_done));

  assert_lost_upgrade_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5 && snp_rdx) |=> (state_o == 3'd4 && !cpu_done));

  assert_mod_share_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && snp_rd && !snp_rdx)
      |=> (state_o == 3'd1 && tr_action == 3'd4));

  assert_record_R12: assert property (@(posedge clk) disable iff (rst)
    tr_valid |-> (tr_old != tr_new || tr_action != 3'd0));

endmodule

bind msi_line_ctrl msi_line_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .state_o   (state_o),
  .bus_rd    (bus_rd),
  .bus_rdx   (bus_rdx),
  .bus_wb    (bus_wb),
  .cpu_ready (cpu_ready),
  .cpu_done  (cpu_done),
  .bus_grant (bus_grant),
  .snp_rd    (snp_rd),
  .snp_rdx   (snp_rdx),
  .tr_valid  (tr_valid),
  .tr_old    (tr_old),
  .tr_new    (tr_new),
  .tr_action (tr_action)
);

// File: tb/sim_msi_line_ctrl.sv
`timescale 1ns/1ps
module sim_msi_line_ctrl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] line_addr = 16'hA5C0;
  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_op = 2'd0;
  logic          cpu_ready, cpu_done;
  logic          snp_rd = 1'b0, snp_rdx = 1'b0, bus_grant = 1'b0;
  logic          bus_rd, bus_rdx, bus_wb;
  logic [2:0]    state_o;
  logic          tr_valid;
  logic [AW-1:0] tr_addr;
  logic [2:0]    tr_old, tr_new, tr_input, tr_action;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  msi_line_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .line_addr(line_addr),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .snp_rd(snp_rd), .snp_rdx(snp_rdx), .bus_grant(bus_grant),
    .bus_rd(bus_rd), .bus_rdx(bus_rdx), .bus_wb(bus_wb), .state_o(state_o),
    .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_old(tr_old), .tr_new(tr_new),
    .tr_input(tr_input), .tr_action(tr_action)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one event for one cycle, starting and ending at a falling edge
  task automatic apply(input logic v, input logic [1:0] op,
                       input logic srd, input logic srdx, input logic g);
    cpu_valid = v; cpu_op = op; snp_rd = srd; snp_rdx = srdx; bus_grant = g;
    @(negedge clk);
    cpu_valid = 1'b0; snp_rd = 1'b0; snp_rdx = 1'b0; bus_grant = 1'b0;
  endtask

  task automatic rec(input string tag, input int o, input int n, input int i, input int a);
    chk({tag, " tr_valid"}, tr_valid, 1);
    chk({tag, " tr_old"}, tr_old, o);
    chk({tag, " tr_new"}, tr_new, n);
    chk({tag, " tr_input"}, tr_input, i);
    chk({tag, " tr_action"}, tr_action, a);
  endtask

  task automatic to_shared();  apply(1, 2'd0, 0, 0, 0); apply(0, 2'd0, 0, 0, 1); endtask
  task automatic to_mod();     apply(1, 2'd1, 0, 0, 0); apply(0, 2'd0, 0, 0, 1); endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 bus reqs", {bus_rd, bus_rdx, bus_wb}, 0);
    chk("R1 tr_valid", tr_valid, 0);
    chk("R1 cpu_done", cpu_done, 0);
    chk("R1 cpu_ready", cpu_ready, 1);
  endtask

  task automatic t_read_miss();
    line_addr = 16'h1234;
    apply(1, 2'd0, 0, 0, 0);
    chk("R3 state wait", state_o, 3);
    chk("R2 bus_rd", bus_rd, 1);
    chk("R12 tr_addr", tr_addr, 16'h1234);
    rec("R3 miss", 0, 3, 1, 1);
    chk("R3 no done yet", cpu_done, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R3 state shared", state_o, 1);
    chk("R3 done", cpu_done, 1);
    chk("R2 bus_rd drop", bus_rd, 0);
    rec("R3 fill", 3, 1, 6, 5);
    @(negedge clk);
    chk("R12 single pulse", tr_valid, 0);
    chk("R3 done pulse", cpu_done, 0);
  endtask

  task automatic t_hits();
    apply(1, 2'd0, 0, 0, 0);
    chk("R9 load hit state", state_o, 1);
    chk("R9 load hit done", cpu_done, 1);
    chk("R9 load hit no rec", tr_valid, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R9 grant stable state", state_o, 1);
    chk("R9 grant stable no rec", tr_valid, 0);
    apply(0, 2'd0, 1, 0, 0);
    chk("R9 snoop rd in shared", state_o, 1);
    chk("R9 snoop rd no rec", tr_valid, 0);
  endtask

  task automatic t_upgrade();
    apply(1, 2'd1, 0, 0, 0);
    chk("R4 upgrade state", state_o, 5);
    chk("R2 bus_rdx", bus_rdx, 1);
    rec("R4 upgrade", 1, 5, 2, 2);
    apply(0, 2'd0, 0, 0, 1);
    chk("R4 owned", state_o, 2);
    chk("R4 done", cpu_done, 1);
    rec("R4 grant", 5, 2, 6, 5);
    apply(1, 2'd1, 0, 0, 0);
    chk("R9 store hit", state_o, 2);
    chk("R9 store hit done", cpu_done, 1);
    chk("R9 store hit no rec", tr_valid, 0);
  endtask

  task automatic t_mod_snoops();
    apply(0, 2'd0, 1, 0, 0);
    chk("R7 mod read snoop", state_o, 1);
    rec("R7 share", 2, 1, 4, 4);
    apply(1, 2'd1, 0, 0, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R4 back to mod", state_o, 2);
    apply(0, 2'd0, 0, 1, 0);
    chk("R7 mod rdx snoop", state_o, 0);
    rec("R7 inval", 2, 0, 5, 4);
  endtask

  task automatic t_write_miss_lost();
    apply(1, 2'd1, 0, 0, 0);
    chk("R4 write miss", state_o, 4);
    rec("R4 miss", 0, 4, 2, 2);
    apply(0, 2'd0, 1, 0, 0);
    chk("R9 snoop in wait own I", state_o, 4);
    chk("R9 no rec", tr_valid, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R4 grant from I", state_o, 2);
    apply(0, 2'd0, 0, 1, 0);
    to_shared();
    apply(1, 2'd1, 0, 0, 0);
    chk("R5 pre", state_o, 5);
    apply(0, 2'd0, 0, 1, 0);
    chk("R5 lost copy", state_o, 4);
    chk("R5 rdx held", bus_rdx, 1);
    chk("R5 no done", cpu_done, 0);
    rec("R5 drop", 5, 4, 5, 6);
    apply(0, 2'd0, 0, 0, 1);
    chk("R5 then owned", state_o, 2);
    chk("R5 done", cpu_done, 1);
  endtask

  task automatic t_writeback();
    apply(1, 2'd2, 0, 0, 0);
    chk("R6 wb wait", state_o, 6);
    chk("R2 bus_wb", bus_wb, 1);
    rec("R6 evict", 2, 6, 3, 3);
    apply(0, 2'd0, 1, 0, 0);
    chk("R6 rd snoop stays", state_o, 6);
    rec("R6 supply rd", 6, 6, 4, 4);
    apply(0, 2'd0, 0, 1, 0);
    chk("R6 rdx snoop inval", state_o, 0);
    chk("R6 rdx done", cpu_done, 1);
    chk("R6 bus_wb drop", bus_wb, 0);
    rec("R6 supply rdx", 6, 0, 5, 4);
    to_mod();
    apply(1, 2'd2, 0, 0, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R6 grant inval", state_o, 0);
    chk("R6 grant done", cpu_done, 1);
    rec("R6 grant", 6, 0, 6, 5);
  endtask

  task automatic t_shared();
    to_shared();
    apply(0, 2'd0, 0, 1, 0);
    chk("R8 shared rdx", state_o, 0);
    chk("R8 no done", cpu_done, 0);
    rec("R8 inval", 1, 0, 5, 6);
    to_shared();
    apply(1, 2'd2, 0, 0, 0);
    chk("R8 evict", state_o, 0);
    chk("R8 evict done", cpu_done, 1);
    rec("R8 evict", 1, 0, 3, 6);
    apply(1, 2'd2, 0, 0, 0);
    chk("R9 evict invalid", state_o, 0);
    chk("R9 evict invalid done", cpu_done, 1);
    chk("R9 evict invalid no rec", tr_valid, 0);
  endtask

  task automatic t_stall();
    apply(1, 2'd0, 0, 0, 0);
    chk("R10 ready low waiting", cpu_ready, 0);
    apply(1, 2'd1, 0, 0, 0);
    chk("R10 ignored req state", state_o, 3);
    chk("R10 ignored req rec", tr_valid, 0);
    chk("R10 ignored req done", cpu_done, 0);
    apply(0, 2'd0, 0, 0, 1);
    apply(0, 2'd0, 0, 1, 0);
    chk("R10 back to invalid", state_o, 0);
    apply(1, 2'd3, 0, 0, 0);
    chk("R10 op3 state", state_o, 0);
    chk("R10 op3 done", cpu_done, 0);
    cpu_valid = 1'b1; cpu_op = 2'd0; snp_rd = 1'b1;
    #1;
    chk("R10 ready low on snoop", cpu_ready, 0);
    @(negedge clk);
    cpu_valid = 1'b0; snp_rd = 1'b0;
    chk("R10 snooped req dropped", state_o, 0);
    chk("R10 snooped req no rec", tr_valid, 0);
  endtask

  task automatic t_priority();
    apply(1, 2'd0, 0, 0, 0);
    apply(0, 2'd0, 1, 0, 1);
    chk("R11 grant lost to snoop", state_o, 3);
    chk("R11 bus_rd held", bus_rd, 1);
    chk("R11 no done", cpu_done, 0);
    apply(0, 2'd0, 0, 0, 1);
    chk("R11 regrant", state_o, 1);
    apply(1, 2'd1, 0, 0, 0);
    apply(0, 2'd0, 0, 1, 1);
    chk("R11 rdx beats grant", state_o, 4);
    apply(0, 2'd0, 0, 0, 1);
    chk("R11 owned", state_o, 2);
    apply(0, 2'd0, 1, 1, 0);
    chk("R11 rdx beats rd", state_o, 0);
    chk("R11 rdx input code", tr_input, 5);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_hits();
    t_upgrade();
    t_mod_snoops();
    t_write_miss_lost();
    t_writeback();
    t_shared();
    t_stall();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule